// File: doc/BRIEF.md
# Halt Drain Controller

This block ends a five-stage in-order pipeline cleanly when the decode stage sees the halt instruction (0xC0001073). Instructions already past decode keep going through write-back. The halt and everything behind it are turned into bubbles. The block does not stop the machine the moment decode sees the halt. Instead it records the address of the instruction just ahead of the halt, which is the halt PC minus one instruction step, and raises exit only once write-back has moved past that address.

The block sits at the decode stage. It takes the raw fetched instruction, the fetch PC, the taken-branch, taken-jump and stall flags, and a write-back slot (a valid flag plus a PC). It returns the filtered decode instruction and the registered decode PC. It also returns an end flag, which the surrounding pipeline uses to force bubbles into execute and later stages. Finally it returns the recorded last-instruction PC and a sticky exit signal.

A halt that reaches write-back still carries its own PC in the write-back slot, with the valid flag high. The pipeline just does nothing with it. A PC that is higher than the recorded address is what completes the drain.

Top module: `halt_drain_ctrl`

## Requirements
- R1: `dec_inst_o` equals the bubble code 0x00000013 in the same cycle that any of `br_taken_i`, `jmp_taken_i`, `stall_i` or `end_flag_o` is high. Otherwise it equals `dec_raw_inst_i`.
- R2: On each clock edge without a stall, `dec_pc_o` loads `fetch_pc_i`. While `stall_i` is high, `dec_pc_o` keeps its value.
- R3: If `dec_inst_o` equals 0xC0001073 while `end_flag_o` is low, then after the next clock edge `end_flag_o` is high and `last_pc_o` equals the previous `dec_pc_o` minus 4.
- R4: A halt code on `dec_raw_inst_i` that is squashed by a branch, a jump or a stall does not set `end_flag_o`.
- R5: Once `end_flag_o` is high it stays high, and `last_pc_o` does not change, even if further halt codes arrive.
- R6: A write-back slot with `wb_valid_i` low leaves the tracked write-back PC unchanged, so a stale `wb_pc_i` cannot raise exit.
- R7: `exit_o` rises in the cycle after a clock edge that accepts a valid write-back PC strictly greater than a nonzero `last_pc_o`. An equal PC does not raise it.
- R8: Once `exit_o` is high it stays high until reset.
- R9: During reset, `end_flag_o`, `last_pc_o`, `exit_o` and `dec_pc_o` are all zero.
- R10: If a halt at PC 4 records a last-instruction PC of zero, `exit_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | PC of the instruction entering decode |
| dec_raw_inst_i | input | 32 | Unfiltered instruction held in decode |
| br_taken_i | input | 1 | Branch taken in execute |
| jmp_taken_i | input | 1 | Jump taken in execute |
| stall_i | input | 1 | Pipeline stall |
| wb_valid_i | input | 1 | Write-back slot carries a PC |
| wb_pc_i | input | 32 | PC in the write-back slot |
| dec_inst_o | output | 32 | Filtered decode instruction |
| dec_pc_o | output | 32 | Registered decode PC |
| end_flag_o | output | 1 | Halt seen; bubbles forced downstream |
| last_pc_o | output | 32 | Recorded PC of the last real instruction |
| exit_o | output | 1 | Drain complete, sticky |

## Verification
The filtered instruction (R1) is combinational, so it is sampled one time step after the inputs change. No clock edge lies in between.

The decode PC, the end flag and the recorded PC (R2 to R5) each pass through a single register. The bench therefore drives at a falling edge and samples at the next falling edge, exactly one rising edge later.

Exit (R6 to R8, R10) depends on the tracked write-back PC register and is then decoded combinationally. A valid write-back slot presented before a rising edge is therefore judged at the following falling edge. Equal, stale and greater PCs are each given one cycle of their own.

// File: rtl/halt_drain_pkg.sv
package halt_drain_pkg;
  localparam logic [31:0] HALT_CODE   = 32'hC000_1073;
  localparam logic [31:0] BUBBLE_CODE = 32'h0000_0013;

  typedef struct packed {
    logic br;
    logic jmp;
    logic stall;
    logic ended;
  } squash_t;
endpackage

// File: rtl/hd_decode_filter.sv
module hd_decode_filter
  import halt_drain_pkg::*;
#(
  parameter int unsigned ILEN = 32,
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic [ILEN-1:0] raw_inst_i,
  input  squash_t         squash_i,
  output logic [ILEN-1:0] inst_o,
  output logic [XLEN-1:0] pc_o,
  output logic            is_halt_o
);
  logic            kill;
  logic [XLEN-1:0] pc_q;

  assign kill      = |squash_i;
  assign inst_o    = kill ? ILEN'(BUBBLE_CODE) : raw_inst_i;
  assign is_halt_o = (inst_o == ILEN'(HALT_CODE)) && !squash_i.ended;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pc_q <= '0;
    else if (!squash_i.stall) pc_q <= fetch_pc_i;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/hd_halt_capture.sv
module hd_halt_capture #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            is_halt_i,
  input  logic [XLEN-1:0] dec_pc_i,
  output logic            end_o,
  output logic [XLEN-1:0] last_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic            end_q;
  logic [XLEN-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q  <= 1'b0;
      last_q <= '0;
    end else if (is_halt_i && !end_q) begin
      end_q  <= 1'b1;
      last_q <= dec_pc_i - STEP;
    end
  end

  assign end_o     = end_q;
  assign last_pc_o = last_q;
endmodule

// File: rtl/hd_exit_monitor.sv
module hd_exit_monitor #(
  parameter int unsigned XLEN      = 32,
  parameter bit          STRICT_GT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wb_valid_i,
  input  logic [XLEN-1:0] wb_pc_i,
  input  logic [XLEN-1:0] last_pc_i,
  output logic [XLEN-1:0] wb_pc_o,
  output logic            exit_o
);
  logic [XLEN-1:0] wb_pc_q;
  logic            exit_q;
  logic            past_last;
  logic            hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wb_pc_q <= '0;
    else if (wb_valid_i) wb_pc_q <= wb_pc_i;
  end

  generate
    if (STRICT_GT) begin : g_gt
      assign past_last = wb_pc_q > last_pc_i;
    end else begin : g_ge
      assign past_last = wb_pc_q >= last_pc_i;
    end
  endgenerate

  // zero marks "no halt recorded"
  assign hit = (last_pc_i != '0) && past_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  exit_q <= 1'b0;
    else if (hit) exit_q <= 1'b1;
  end

  assign exit_o  = exit_q | hit;
  assign wb_pc_o = wb_pc_q;
endmodule

// File: rtl/halt_drain_ctrl.sv
module halt_drain_ctrl
  import halt_drain_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned ILEN      = 32,
  parameter int unsigned PC_STEP   = 4,
  parameter bit          STRICT_GT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic [ILEN-1:0] dec_raw_inst_i,
  input  logic            br_taken_i,
  input  logic            jmp_taken_i,
  input  logic            stall_i,
  input  logic            wb_valid_i,
  input  logic [XLEN-1:0] wb_pc_i,
  output logic [ILEN-1:0] dec_inst_o,
  output logic [XLEN-1:0] dec_pc_o,
  output logic            end_flag_o,
  output logic [XLEN-1:0] last_pc_o,
  output logic            exit_o
);
  squash_t         squash;
  logic            is_halt;
  logic            end_q;
  logic [XLEN-1:0] wb_pc_q;

  assign squash = '{br: br_taken_i, jmp: jmp_taken_i, stall: stall_i, ended: end_q};

  hd_decode_filter #(.ILEN(ILEN), .XLEN(XLEN)) u_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_pc_i (fetch_pc_i),
    .raw_inst_i (dec_raw_inst_i),
    .squash_i   (squash),
    .inst_o     (dec_inst_o),
    .pc_o       (dec_pc_o),
    .is_halt_o  (is_halt)
  );

  hd_halt_capture #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .is_halt_i (is_halt),
    .dec_pc_i  (dec_pc_o),
    .end_o     (end_q),
    .last_pc_o (last_pc_o)
  );

  hd_exit_monitor #(.XLEN(XLEN), .STRICT_GT(STRICT_GT)) u_exit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wb_valid_i (wb_valid_i),
    .wb_pc_i    (wb_pc_i),
    .last_pc_i  (last_pc_o),
    .wb_pc_o    (wb_pc_q),
    .exit_o     (exit_o)
  );

  assign end_flag_o = end_q;
endmodule

// File: rtl/halt_drain_chk.sv
module halt_drain_chk
  import halt_drain_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ILEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            br_taken_i,
  input logic            jmp_taken_i,
  input logic            stall_i,
  input logic [ILEN-1:0] dec_inst_o,
  input logic [XLEN-1:0] dec_pc_o,
  input logic            end_flag_o,
  input logic [XLEN-1:0] last_pc_o,
  input logic            exit_o,
  input logic [XLEN-1:0] wb_pc_q
);
  assert_bubble_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken_i || jmp_taken_i || stall_i || end_flag_o) |-> dec_inst_o == ILEN'(BUBBLE_CODE));

  assert_pc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(dec_pc_o));

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_inst_o == ILEN'(HALT_CODE) && !end_flag_o)
      |=> (end_flag_o && last_pc_o == $past(dec_pc_o) - XLEN'(4)));

  assert_end_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_flag_o |=> (end_flag_o && $stable(last_pc_o)));

  assert_exit_due_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_pc_o != '0 && wb_pc_q > last_pc_o) |-> exit_o);

  assert_exit_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> exit_o);

  assert_no_exit_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_pc_o == '0) |-> !exit_o);
endmodule

bind halt_drain_ctrl halt_drain_chk #(.XLEN(XLEN), .ILEN(ILEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .br_taken_i  (br_taken_i),
  .jmp_taken_i (jmp_taken_i),
  .stall_i     (stall_i),
  .dec_inst_o  (dec_inst_o),
  .dec_pc_o    (dec_pc_o),
  .end_flag_o  (end_flag_o),
  .last_pc_o   (last_pc_o),
  .exit_o      (exit_o),
  .wb_pc_q     (wb_pc_q)
);

// File: tb/tb_halt_drain_ctrl.sv
`timescale 1ns/1ps
module tb_halt_drain_ctrl;
  localparam logic [31:0] HALT = 32'hC000_1073;
  localparam logic [31:0] NOP  = 32'h0000_0013;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic [31:0] dec_raw_inst_i = '0;
  logic        br_taken_i = 1'b0, jmp_taken_i = 1'b0, stall_i = 1'b0;
  logic        wb_valid_i = 1'b0;
  logic [31:0] wb_pc_i = '0;
  logic [31:0] dec_inst_o, dec_pc_o, last_pc_o;
  logic        end_flag_o, exit_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  halt_drain_ctrl dut (
    .clk_i, .rst_ni, .fetch_pc_i, .dec_raw_inst_i, .br_taken_i, .jmp_taken_i,
    .stall_i, .wb_valid_i, .wb_pc_i, .dec_inst_o, .dec_pc_o, .end_flag_o,
    .last_pc_o, .exit_o
  );

  // {raw, br, jmp, stall, expect_bubble}
  localparam logic [35:0] VEC [8] = '{
    {32'h0050_0513, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0090_0593, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'h02A5_D633, 1'b0, 1'b1, 1'b0, 1'b1},
    {32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1},
    {HALT,          1'b1, 1'b0, 1'b0, 1'b1},
    {HALT,          1'b0, 1'b0, 1'b1, 1'b1},
    {32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1},
    {32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk_i);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    // R9: reset state
    #12;
    check("R9 end", {31'b0, end_flag_o}, 32'h0);
    check("R9 last", last_pc_o, 32'h0);
    check("R9 exit", {31'b0, exit_o}, 32'h0);
    check("R9 dec_pc", dec_pc_o, 32'h0);
    tick();
    rst_ni = 1'b1;

    // R1: filter table
    foreach (VEC[i]) begin
      tick();
      {dec_raw_inst_i, br_taken_i, jmp_taken_i, stall_i} = VEC[i][35:1];
      #1;
      check("R1 table", dec_inst_o, VEC[i][0] ? NOP : VEC[i][35:4]);
    end
    tick();
    {br_taken_i, jmp_taken_i, stall_i} = 3'b000;
    dec_raw_inst_i = 32'h0000_0013;
    tick();
    // R4: squashed halts left no end flag
    check("R4 squashed halt", {31'b0, end_flag_o}, 32'h0);

    // R2: decode PC load and hold
    fetch_pc_i = 32'h100;
    tick();
    check("R2 load", dec_pc_o, 32'h100);
    stall_i = 1'b1; fetch_pc_i = 32'h104;
    tick();
    check("R2 hold", dec_pc_o, 32'h100);
    stall_i = 1'b0;
    tick();
    check("R2 reload", dec_pc_o, 32'h104);

    // R4: jump-squashed halt
    jmp_taken_i = 1'b1; dec_raw_inst_i = HALT;
    tick();
    check("R4 jump squash", {31'b0, end_flag_o}, 32'h0);
    jmp_taken_i = 1'b0; dec_raw_inst_i = NOP;

    // R3: capture
    fetch_pc_i = 32'h200;
    tick();
    dec_raw_inst_i = HALT; fetch_pc_i = 32'h204;
    tick();
    check("R3 end", {31'b0, end_flag_o}, 32'h1);
    check("R3 last", last_pc_o, 32'h1FC);
    #1;
    check("R1 ended bubble", dec_inst_o, NOP);

    // R5: second halt ignored
    fetch_pc_i = 32'h300;
    tick();
    tick();
    check("R5 last held", last_pc_o, 32'h1FC);
    check("R5 end held", {31'b0, end_flag_o}, 32'h1);

    // R6: invalid slot with big PC
    wb_valid_i = 1'b0; wb_pc_i = 32'h800;
    tick();
    check("R6 stale", {31'b0, exit_o}, 32'h0);
    // R7: equal not enough
    wb_valid_i = 1'b1; wb_pc_i = 32'h1FC;
    tick();
    check("R7 equal", {31'b0, exit_o}, 32'h0);
    wb_pc_i = 32'h200;
    tick();
    check("R7 greater", {31'b0, exit_o}, 32'h1);
    // R8: sticky
    wb_pc_i = 32'h0;
    tick();
    tick();
    check("R8 sticky", {31'b0, exit_o}, 32'h1);
    wb_valid_i = 1'b0;

    // R9 again, then R10
    rst_ni = 1'b0;
    #1;
    check("R9 exit cleared", {31'b0, exit_o}, 32'h0);
    check("R9 end cleared", {31'b0, end_flag_o}, 32'h0);
    tick();
    rst_ni = 1'b1;
    dec_raw_inst_i = NOP; fetch_pc_i = 32'h4;
    tick();
    dec_raw_inst_i = HALT;
    tick();
    check("R10 end", {31'b0, end_flag_o}, 32'h1);
    check("R10 last", last_pc_o, 32'h0);
    wb_valid_i = 1'b1; wb_pc_i = 32'h100;
    tick();
    tick();
    check("R10 no exit", {31'b0, exit_o}, 32'h0);

    summary();
    $finish;
  end
endmodule